// File: doc/BRIEF.md
# SDRAM Refresh and Power-Down Sequencer

This block sits beside a memory controller and owns the clock-enable and the three command strobes of an SDRAM whenever refresh or low-power work is due. The controller raises a request for an auto-refresh, for self-refresh entry, or for power-down entry. The sequencer stores each request until three things are true: every bank reports precharged, the precharge recovery window has run out, and no earlier recovery window is still counting. It then drives the matching pin pattern. Exit from self-refresh is requested by the controller. Exit from power-down is requested by the controller or forced by an internal limit, because the device does no refreshing while powered down.

After each command or exit the block counts the recovery time the device needs. A ready output tells the controller when it may issue normal access commands again. All timing values are parameters counted in clock cycles: `TRC`, `TRP`, `PD_MAX` and `PD_EXIT`. Pins and status come straight from registers. A request sampled at one rising edge shows its effect on the pins in the cycle that follows that edge.

Top module: `sdram_rfpd_seq`

## Requirements
- R1: An auto-refresh appears for exactly one cycle as cke_o=1, ras_n_o=0, cas_n_o=0, we_n_o=1. In every other cycle the strobes are all high (no-operation), except for the self-refresh entry cycle.
- R2: Self-refresh entry appears for one cycle as cke_o=0, ras_n_o=0, cas_n_o=0, we_n_o=1, with mode_o=1. It is followed by no-operation strobes with cke_o held low until exit.
- R3: No refresh is issued and no mode is entered unless all_pre_i is high at the deciding edge and the precharge window has elapsed. After pre_cmd_i is sampled at an edge, the earliest action shows on the pins TRP+2 cycles later.
- R4: A request that arrives while all_pre_i is low is kept, not lost. It is served at the first edge where issuing is allowed.
- R5: When several requests are pending, refresh goes first, then self-refresh entry, then power-down entry.
- R6: ready_o is low in the refresh cycle and goes high TRC cycles after it. A second refresh cannot appear earlier than TRC+1 cycles after the first.
- R7: sr_exit_i sampled while in self-refresh raises cke_o in the next cycle with mode_o=0 and no-operation strobes. ready_o follows TRC cycles after that exit cycle.
- R8: Power-down entry drives cke_o low with no-operation strobes and mode_o=2.
- R9: pd_exit_i sampled in power-down raises cke_o in the next cycle with ready_o low. ready_o rises PD_EXIT cycles later.
- R10: cke_o stays low in power-down for at most PD_MAX consecutive cycles. Without an exit request the block exits on its own after exactly PD_MAX cycles.
- R11: An exit request has no effect outside its own mode: sr_exit_i or pd_exit_i in idle, and pd_exit_i in self-refresh, leave the pins, mode and ready unchanged.
- R12: During and right after reset: cke_o=1, all strobes high, mode_o=0, ready_o=1. ready_o is high only in idle with no recovery counting, and it implies no-operation strobes with cke_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| all_pre_i | input | 1 | High when every bank is precharged |
| pre_cmd_i | input | 1 | Pulse: controller issued a precharge this cycle (starts the TRP window) |
| ref_req_i | input | 1 | Request one auto-refresh |
| sr_enter_i | input | 1 | Request self-refresh entry |
| sr_exit_i | input | 1 | Leave self-refresh (acted on only in self-refresh) |
| pd_enter_i | input | 1 | Request power-down entry |
| pd_exit_i | input | 1 | Leave power-down (acted on only in power-down) |
| cke_o | output | 1 | Clock enable to the SDRAM |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ready_o | output | 1 | Normal access may be issued |
| mode_o | output | 2 | 0 idle, 1 self-refresh, 2 power-down |

## Verification
Each request sampled at an edge shows on the pins in the cycle after that edge. Recovery follows on ready_o exactly TRC cycles after a refresh or a self-refresh exit, and PD_EXIT cycles after a power-down exit. After a precharge pulse, the first entry shows TRP+2 cycles later. A forced power-down exit comes after exactly PD_MAX low cycles. The bench drives and samples on falling edges, so every cycle count is a count of falling edges after the driving one. A behavioural model is stepped on each rising edge and compared with all outputs at every falling edge. Directed checks additionally measure these distances by counting falling edges.

// File: rtl/rfpd_pkg.sv
package rfpd_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_SREF = 2'd1,
        MODE_PDN  = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_REF = 2'd1,
        CMD_SRE = 2'd2
    } cmd_e;

    typedef struct packed {
        mode_e mode;
        logic  cke;
        cmd_e  cmd;
    } seq_t;

    localparam int unsigned NUM_REQ = 3;
    localparam int unsigned REQ_REF = 0;
    localparam int unsigned REQ_SRE = 1;
    localparam int unsigned REQ_PDE = 2;

endpackage

// File: rtl/rfpd_downcnt.sv
module rfpd_downcnt #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o,
    output logic         zero_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/rfpd_pend.sv
module rfpd_pend #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic         serve_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);

    logic [N-1:0] pend_d, pend_q;
    logic [N-1:0] live;

    assign live  = pend_q | req_i;
    assign any_o = |live;

    for (genvar i = 0; i < N; i++) begin : g_pri
        if (i == 0) begin : g_first
            assign grant_o[i] = live[i];
        end else begin : g_rest
            assign grant_o[i] = live[i] & ~(|live[i-1:0]);
        end
    end

    always_comb begin
        pend_d = live;
        if (serve_i) begin
            pend_d = live & ~grant_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/rfpd_pin_enc.sv
module rfpd_pin_enc
    import rfpd_pkg::*;
(
    input  cmd_e cmd_i,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic we_n_o
);

    always_comb begin
        ras_n_o = 1'b1;
        cas_n_o = 1'b1;
        we_n_o  = 1'b1;
        unique case (cmd_i)
            CMD_REF, CMD_SRE: begin
                ras_n_o = 1'b0;
                cas_n_o = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_rfpd_seq.sv
module sdram_rfpd_seq
    import rfpd_pkg::*;
#(
    parameter int unsigned TRC     = 7,
    parameter int unsigned TRP     = 3,
    parameter int unsigned PD_MAX  = 1000,
    parameter int unsigned PD_EXIT = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       all_pre_i,
    input  logic       pre_cmd_i,
    input  logic       ref_req_i,
    input  logic       sr_enter_i,
    input  logic       sr_exit_i,
    input  logic       pd_enter_i,
    input  logic       pd_exit_i,
    output logic       cke_o,
    output logic       ras_n_o,
    output logic       cas_n_o,
    output logic       we_n_o,
    output logic       ready_o,
    output logic [1:0] mode_o
);

    localparam int unsigned REC_MAX = (TRC > PD_EXIT) ? TRC : PD_EXIT;
    localparam int unsigned REC_W   = $clog2(REC_MAX + 1);
    localparam int unsigned TRP_W   = $clog2(TRP + 1);
    localparam int unsigned PD_W    = $clog2(PD_MAX + 1);

    seq_t seq_d, seq_q;

    logic               rec_load;
    logic [REC_W-1:0]   rec_val;
    logic [REC_W-1:0]   rec_cnt;
    logic               rec_zero;
    logic [TRP_W-1:0]   trp_cnt;
    logic               trp_zero;
    logic               pd_load;
    logic [PD_W-1:0]    pd_cnt;
    logic               pd_zero;
    logic               serve;
    logic [NUM_REQ-1:0] req_vec;
    logic [NUM_REQ-1:0] grant;
    logic               pend_any;
    logic               issue_ok;

    assign req_vec[REQ_REF] = ref_req_i;
    assign req_vec[REQ_SRE] = sr_enter_i;
    assign req_vec[REQ_PDE] = pd_enter_i;

    rfpd_pend #(.N(NUM_REQ)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_vec),
        .serve_i (serve),
        .grant_o (grant),
        .any_o   (pend_any)
    );

    rfpd_downcnt #(.W(REC_W)) u_rec_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (rec_load),
        .load_val_i (rec_val),
        .dec_i      (1'b1),
        .cnt_o      (rec_cnt),
        .zero_o     (rec_zero)
    );

    rfpd_downcnt #(.W(TRP_W)) u_trp_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (pre_cmd_i),
        .load_val_i (TRP_W'(TRP)),
        .dec_i      (1'b1),
        .cnt_o      (trp_cnt),
        .zero_o     (trp_zero)
    );

    rfpd_downcnt #(.W(PD_W)) u_pd_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (pd_load),
        .load_val_i (PD_W'(PD_MAX - 1)),
        .dec_i      (seq_q.mode == MODE_PDN),
        .cnt_o      (pd_cnt),
        .zero_o     (pd_zero)
    );

    assign issue_ok = all_pre_i && !pre_cmd_i && rec_zero && trp_zero;

    always_comb begin
        seq_d    = seq_q;
        seq_d.cmd = CMD_NOP;
        rec_load = 1'b0;
        rec_val  = '0;
        pd_load  = 1'b0;
        serve    = 1'b0;
        unique case (seq_q.mode)
            MODE_IDLE: begin
                seq_d.cke = 1'b1;
                if (issue_ok && pend_any) begin
                    serve = 1'b1;
                    if (grant[REQ_REF]) begin
                        seq_d.cmd = CMD_REF;
                        rec_load  = 1'b1;
                        rec_val   = REC_W'(TRC);
                    end else if (grant[REQ_SRE]) begin
                        seq_d.cmd  = CMD_SRE;
                        seq_d.cke  = 1'b0;
                        seq_d.mode = MODE_SREF;
                    end else begin
                        seq_d.cke  = 1'b0;
                        seq_d.mode = MODE_PDN;
                        pd_load    = 1'b1;
                    end
                end
            end
            MODE_SREF: begin
                seq_d.cke = 1'b0;
                if (sr_exit_i) begin
                    seq_d.cke  = 1'b1;
                    seq_d.mode = MODE_IDLE;
                    rec_load   = 1'b1;
                    rec_val    = REC_W'(TRC);
                end
            end
            MODE_PDN: begin
                seq_d.cke = 1'b0;
                if (pd_exit_i || pd_zero) begin
                    seq_d.cke  = 1'b1;
                    seq_d.mode = MODE_IDLE;
                    rec_load   = 1'b1;
                    rec_val    = REC_W'(PD_EXIT);
                end
            end
            default: begin
                seq_d.cke  = 1'b1;
                seq_d.mode = MODE_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{mode: MODE_IDLE, cke: 1'b1, cmd: CMD_NOP};
        end else begin
            seq_q <= seq_d;
        end
    end

    rfpd_pin_enc u_pin_enc (
        .cmd_i   (seq_q.cmd),
        .ras_n_o (ras_n_o),
        .cas_n_o (cas_n_o),
        .we_n_o  (we_n_o)
    );

    assign cke_o   = seq_q.cke;
    assign mode_o  = seq_q.mode;
    assign ready_o = (seq_q.mode == MODE_IDLE) && rec_zero;

endmodule

// File: rtl/rfpd_chk.sv
module rfpd_chk #(
    parameter int unsigned TRC    = 7,
    parameter int unsigned TRP    = 3,
    parameter int unsigned PD_MAX = 1000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       all_pre_i,
    input logic       pre_cmd_i,
    input logic       cke_o,
    input logic       ras_n_o,
    input logic       cas_n_o,
    input logic       we_n_o,
    input logic       ready_o,
    input logic [1:0] mode_o
);

    logic is_ref;
    logic is_nop;
    logic sr_exit_cyc;
    logic prev_sref_q;
    int   since_rec_q;
    int   since_pre_q;
    int   low_cnt_q;

    assign is_ref      = cke_o && !ras_n_o && !cas_n_o && we_n_o;
    assign is_nop      = ras_n_o && cas_n_o && we_n_o;
    assign sr_exit_cyc = cke_o && prev_sref_q && (mode_o == 2'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_sref_q <= 1'b0;
            since_rec_q <= TRC + 1;
            since_pre_q <= TRP + 2;
            low_cnt_q   <= 0;
        end else begin
            prev_sref_q <= (mode_o == 2'd1);
            if (is_ref || sr_exit_cyc) begin
                since_rec_q <= 1;
            end else if (since_rec_q < TRC + 1) begin
                since_rec_q <= since_rec_q + 1;
            end
            if (pre_cmd_i) begin
                since_pre_q <= 1;
            end else if (since_pre_q < TRP + 2) begin
                since_pre_q <= since_pre_q + 1;
            end
            if ((mode_o == 2'd2) && !cke_o) begin
                low_cnt_q <= low_cnt_q + 1;
            end else begin
                low_cnt_q <= 0;
            end
        end
    end

    p_ref_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |=> !is_ref);

    p_sref_cke_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1) |-> !cke_o);

    p_entry_precharged_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref || $fell(cke_o)) |-> $past(all_pre_i));

    p_entry_after_trp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref || $fell(cke_o)) |-> (since_pre_q > TRP));

    p_ready_after_trc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (since_rec_q >= TRC) && !is_ref && !sr_exit_cyc);

    p_ref_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (since_rec_q >= TRC));

    p_pdn_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |-> (!cke_o && is_nop));

    p_exit_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_o) |-> !ready_o);

    p_pd_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |-> (low_cnt_q < PD_MAX));

    p_ready_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (cke_o && is_nop && (mode_o == 2'd0)));

endmodule

bind sdram_rfpd_seq rfpd_chk #(
    .TRC    (TRC),
    .TRP    (TRP),
    .PD_MAX (PD_MAX)
) u_rfpd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .all_pre_i (all_pre_i),
    .pre_cmd_i (pre_cmd_i),
    .cke_o     (cke_o),
    .ras_n_o   (ras_n_o),
    .cas_n_o   (cas_n_o),
    .we_n_o    (we_n_o),
    .ready_o   (ready_o),
    .mode_o    (mode_o)
);

// File: tb/sdram_rfpd_seq_bench.sv
module sdram_rfpd_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TRC     = 5;
    localparam int TRP     = 3;
    localparam int PD_MAX  = 12;
    localparam int PD_EXIT = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic all_pre = 1'b1;
    logic pre_cmd = 1'b0;
    logic ref_req = 1'b0;
    logic sr_en = 1'b0;
    logic sr_ex = 1'b0;
    logic pd_en = 1'b0;
    logic pd_ex = 1'b0;
    logic cke_o, ras_n_o, cas_n_o, we_n_o, ready_o;
    logic [1:0] mode_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_rfpd_seq #(
        .TRC(TRC), .TRP(TRP), .PD_MAX(PD_MAX), .PD_EXIT(PD_EXIT)
    ) u_sdram_rfpd_seq (
        .clk(clk), .rst_n(rst_n), .all_pre_i(all_pre), .pre_cmd_i(pre_cmd),
        .ref_req_i(ref_req), .sr_enter_i(sr_en), .sr_exit_i(sr_ex),
        .pd_enter_i(pd_en), .pd_exit_i(pd_ex), .cke_o(cke_o),
        .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
        .ready_o(ready_o), .mode_o(mode_o)
    );

    int    n_run = 0;
    int    n_fail = 0;
    string phase = "R12";
    bit    done = 1'b0;

    task automatic check(string tag, int act, int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // behavioural reference: integers for timers, an array of flags for requests
    int m_mode = 0;
    int m_cke  = 1;
    int m_cmd  = 0;
    int m_rec  = 0;
    int m_trp  = 0;
    int m_pd   = 0;
    int pend [3] = '{0, 0, 0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cke = 1; m_cmd = 0; m_rec = 0; m_trp = 0; m_pd = 0;
            pend = '{0, 0, 0};
        end else begin
            int live [3];
            int pick;
            bit ok;
            int n_rec, n_trp;
            live[0] = pend[0] | int'(ref_req);
            live[1] = pend[1] | int'(sr_en);
            live[2] = pend[2] | int'(pd_en);
            ok    = all_pre && !pre_cmd && (m_rec == 0) && (m_trp == 0);
            n_rec = (m_rec > 0) ? m_rec - 1 : 0;
            n_trp = pre_cmd ? TRP : ((m_trp > 0) ? m_trp - 1 : 0);
            m_cmd = 0;
            pend  = live;
            if (m_mode == 0) begin
                pick = -1;
                for (int i = 2; i >= 0; i--) if (live[i] != 0) pick = i;
                if (ok && pick >= 0) begin
                    pend[pick] = 0;
                    if (pick == 0) begin
                        m_cmd = 1; n_rec = TRC;
                    end else if (pick == 1) begin
                        m_cmd = 2; m_cke = 0; m_mode = 1;
                    end else begin
                        m_cke = 0; m_mode = 2; m_pd = PD_MAX - 1;
                    end
                end
            end else if (m_mode == 1) begin
                if (sr_ex) begin
                    m_cke = 1; m_mode = 0; n_rec = TRC;
                end
            end else begin
                if (pd_ex || m_pd == 0) begin
                    m_cke = 1; m_mode = 0; n_rec = PD_EXIT;
                end else begin
                    m_pd = m_pd - 1;
                end
            end
            m_rec = n_rec;
            m_trp = n_trp;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int exp_v;
            int act_v;
            int m_ready;
            m_ready = (m_mode == 0 && m_rec == 0) ? 1 : 0;
            exp_v = (m_cke << 6) | (((m_cmd == 0) ? 7 : 1) << 3) | (m_ready << 2) | m_mode;
            act_v = int'({cke_o, ras_n_o, cas_n_o, we_n_o, ready_o, mode_o});
            check({phase, " outputs vs model"}, act_v, exp_v);
        end
    end

    function automatic bit pins_ref();
        return cke_o && !ras_n_o && !cas_n_o && we_n_o;
    endfunction

    task automatic clear_all();
        pre_cmd = 0; ref_req = 0; sr_en = 0; sr_ex = 0; pd_en = 0; pd_ex = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : scenario
        int k;
        int cnt;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 cke in reset", int'(cke_o), 1);
        check("R12 strobes in reset", int'({ras_n_o, cas_n_o, we_n_o}), 7);
        check("R12 mode in reset", int'(mode_o), 0);
        check("R12 ready in reset", int'(ready_o), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 single refresh, R6 recovery
        phase = "R1";
        ref_req = 1; @(negedge clk); clear_all();
        check("R1 refresh pins", int'({cke_o, ras_n_o, cas_n_o, we_n_o}), 4'b1001);
        check("R6 ready low in refresh cycle", int'(ready_o), 0);
        k = 1;
        while (!ready_o && k < 50) begin @(negedge clk); k++; end
        check("R6 refresh to ready distance", k, TRC + 1);

        // R6 back-to-back refreshes
        phase = "R6";
        @(negedge clk);
        ref_req = 1; @(negedge clk);
        check("R6 first refresh", int'(pins_ref()), 1);
        @(negedge clk); clear_all();
        k = 2;
        while (!pins_ref() && k < 50) begin @(negedge clk); k++; end
        check("R6 refresh gap", k, TRC + 2);
        repeat (TRC + 2) @(negedge clk);

        // R4 request held while banks not precharged
        phase = "R4";
        all_pre = 0;
        ref_req = 1; @(negedge clk); clear_all();
        cnt = 0;
        for (int i = 0; i < 6; i++) begin
            if (pins_ref()) cnt++;
            @(negedge clk);
        end
        check("R4 no refresh while unprecharged", cnt, 0);
        all_pre = 1; @(negedge clk);
        check("R4 held refresh served", int'(pins_ref()), 1);
        repeat (TRC + 2) @(negedge clk);

        // R3 precharge window gates power-down entry, R8 entry, R9 exit
        phase = "R3";
        pre_cmd = 1; pd_en = 1; @(negedge clk); clear_all();
        k = 1;
        while (cke_o && k < 50) begin @(negedge clk); k++; end
        check("R3 entry delay after precharge", k, TRP + 2);
        phase = "R8";
        check("R8 power-down mode", int'(mode_o), 2);
        check("R8 power-down strobes", int'({ras_n_o, cas_n_o, we_n_o}), 7);
        repeat (3) @(negedge clk);
        phase = "R9";
        pd_ex = 1; @(negedge clk); clear_all();
        check("R9 cke up after exit", int'(cke_o), 1);
        check("R9 ready low in exit cycle", int'(ready_o), 0);
        repeat (PD_EXIT) @(negedge clk);
        check("R9 ready after exit latency", int'(ready_o), 1);
        repeat (2) @(negedge clk);

        // R10 forced exit
        phase = "R10";
        pd_en = 1; @(negedge clk); clear_all();
        cnt = 0;
        while (!cke_o && cnt < 100) begin cnt++; @(negedge clk); end
        check("R10 power-down length", cnt, PD_MAX);
        check("R10 mode after forced exit", int'(mode_o), 0);
        repeat (3) @(negedge clk);

        // R2 self-refresh entry, R11 wrong exit ignored, R7 exit
        phase = "R2";
        sr_en = 1; @(negedge clk); clear_all();
        check("R2 self-refresh entry pins", int'({cke_o, ras_n_o, cas_n_o, we_n_o}), 4'b0001);
        check("R2 self-refresh mode", int'(mode_o), 1);
        @(negedge clk);
        check("R2 held pins", int'({cke_o, ras_n_o, cas_n_o, we_n_o}), 4'b0111);
        phase = "R11";
        pd_ex = 1; @(negedge clk); clear_all();
        repeat (2) @(negedge clk);
        check("R11 power-down exit ignored in self-refresh", int'({cke_o, mode_o}), 3'b001);
        phase = "R7";
        sr_ex = 1; @(negedge clk); clear_all();
        check("R7 cke up and idle", int'({cke_o, mode_o}), 3'b100);
        check("R7 ready low in exit cycle", int'(ready_o), 0);
        k = 1;
        while (!ready_o && k < 50) begin @(negedge clk); k++; end
        check("R7 exit to ready distance", k, TRC + 1);

        // R11 exits in idle ignored
        phase = "R11";
        sr_ex = 1; pd_ex = 1; @(negedge clk); clear_all();
        for (int i = 0; i < 3; i++) begin
            check("R11 idle unaffected by exit requests",
                  int'({cke_o, ready_o, mode_o}), 4'b1100);
            @(negedge clk);
        end

        // R5 priority among pending requests
        phase = "R5";
        all_pre = 0;
        pd_en = 1; @(negedge clk); clear_all();
        sr_en = 1; @(negedge clk); clear_all();
        ref_req = 1; @(negedge clk); clear_all();
        @(negedge clk);
        all_pre = 1; @(negedge clk);
        check("R5 refresh served first", int'(pins_ref()), 1);
        k = 0;
        while (mode_o == 2'd0 && k < 50) begin @(negedge clk); k++; end
        check("R5 self-refresh second", int'(mode_o), 1);
        sr_ex = 1; @(negedge clk); clear_all();
        k = 0;
        while (mode_o == 2'd0 && k < 50) begin @(negedge clk); k++; end
        check("R5 power-down last", int'(mode_o), 2);
        pd_ex = 1; @(negedge clk); clear_all();
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule